// File: doc/BRIEF.md
# Machine-Mode CSR Unit

This block holds the machine-level control and status registers of a small 32-bit integer core that runs only at the highest privilege level. The decode stage presents one register access per cycle. An access carries an operation (read, write, bit-set or bit-clear), a 12-bit register address and an operand. The block returns the old register value on a combinational read port. In the same cycle it flags any access that names an unknown register or tries to modify a read-only one. A flagged access changes no state. The core is expected to turn it into an illegal-instruction trap.

On the trap side, the core raises a request that carries one of three causes, the program counter of the faulting instruction and that instruction's encoding. The block saves the return address. It records a cause code and a trap value, where the trap value depends on the cause. It stacks the interrupt-enable bit and presents the handler address. A return request restores the enable bit, and the saved address is always visible on a port. A cycle counter and a retired-instruction counter run alongside. Both are writable, and a software write takes precedence over the count in that cycle.

Writable fields that hold a restricted set of values are legalized when written. A write of a value outside the set leaves a legal value in place, so software that reads a register back always sees a value the hardware supports.

Top module: `mcsr_unit`

## Requirements
- R1: After reset, the registers read as follows. The ISA register (address 0x301) reads 0x40000100. The hart-id register (0xF14) reads the HART_ID parameter. The status register (0x300) reads 0x00001800. The trap-vector register (0x305) reads RESET_VEC with bits [1:0] cleared. The exception-PC (0x341), cause (0x342), trap-value (0x343) and retired-count (0xB02) registers read 0.
- R2: The csr_op encoding is 0 = none, 1 = read, 2 = write, 3 = set, 4 = clear, and 5 to 7 = none. Any access (codes 1 to 4) raises illegal_o in the same cycle if the address is outside {0x300, 0x301, 0x305, 0x341, 0x342, 0x343, 0xB00, 0xB02, 0xF14}. Codes 2 to 4 also raise illegal_o when address bits [11:10] are 2'b11 (read-only). A flagged access changes no register, and no other access raises illegal_o.
- R3: A write to the status register replaces the value, a set ORs the operand in, and a clear removes the operand's bits. Only bit 3 (enable) and bit 7 (previous enable) are stored. Bits [12:11] always read 2'b11, and all other bits read 0.
- R4: The ISA register accepts writes, sets and clears without raising illegal_o, and it always reads 0x40000100.
- R5: A write to the trap-vector register stores bits [31:2] as written. It stores mode bits [1:0] only when the written mode is 0 or 1. A mode of 2 or 3 keeps the previously held mode.
- R6: Bits [1:0] of the exception-PC register always read 0, whether the register is loaded by a software write or by a trap.
- R7: The trap kind encoding is 0 = illegal instruction, 1 = environment call, 2 = breakpoint, and 3 = handled as illegal instruction. A trap loads the cause register with 2, 11, 3 and 2 respectively, and loads the exception-PC register with trap_pc.
- R8: A trap loads the trap-value register with the instruction word for an illegal-instruction trap, with 0 for an environment call, and with trap_pc for a breakpoint.
- R9: A trap copies the enable bit into the previous-enable bit and clears the enable bit. A return copies the previous-enable bit into the enable bit and sets the previous-enable bit.
- R10: trap_vector_o equals the trap-vector register with bits [1:0] cleared, and ret_addr_o equals the exception-PC register.
- R11: The cycle counter (0xB00) rises by 1 on every clock edge. In a cycle where software writes it, the counter takes the written value instead of counting.
- R12: The retired counter (0xB02) rises by 1 on each edge where retire_i is high. In a cycle where software writes it, it takes the written value and the retire of that cycle is not counted.
- R13: A trap request, or failing that a return request, takes priority over a register access in the same cycle. That access then changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_op | input | 3 | Access operation code |
| csr_addr | input | 12 | Register address |
| csr_wdata | input | 32 | Write, set or clear operand |
| csr_rdata | output | 32 | Current value of the addressed register |
| illegal_o | output | 1 | Access is not allowed |
| retire_i | input | 1 | One instruction retired this cycle |
| trap_req | input | 1 | Take a trap this cycle |
| trap_kind | input | 2 | Trap cause selector |
| trap_pc | input | 32 | PC of the trapping instruction |
| trap_instr | input | 32 | Encoding of the trapping instruction |
| mret_req | input | 1 | Return from trap this cycle |
| trap_vector_o | output | 32 | Handler address |
| ret_addr_o | output | 32 | Return address for a trap return |

## Verification
Two cases are hard to reach from the ports. The first is a counter write that lands in the same cycle as an increment, where the write must win and the increment must be lost. The stimulus gets there by pulsing retire_i while writing the retired counter. For the cycle counter, which advances on every edge, it counts edges from the write onward. The second is an access that collides with a trap or a return. The bench places a write to a trap-written register and a trap in the same cycle, then checks that the trap's value is the one held. Legality is covered by a full sweep over every operation code against every implemented address plus several unused ones, and by a sweep of all four mode values over two base addresses.

// File: rtl/mcsr_pkg.sv
package mcsr_pkg;

    localparam int XLEN = 32;

    localparam logic [2:0] OP_NONE  = 3'd0;
    localparam logic [2:0] OP_READ  = 3'd1;
    localparam logic [2:0] OP_WRITE = 3'd2;
    localparam logic [2:0] OP_SET   = 3'd3;
    localparam logic [2:0] OP_CLR   = 3'd4;

    localparam logic [1:0] TK_ILLEGAL = 2'd0;
    localparam logic [1:0] TK_ECALL   = 2'd1;
    localparam logic [1:0] TK_EBREAK  = 2'd2;

    localparam logic [11:0] A_STATUS  = 12'h300;
    localparam logic [11:0] A_ISA     = 12'h301;
    localparam logic [11:0] A_TVEC    = 12'h305;
    localparam logic [11:0] A_EPC     = 12'h341;
    localparam logic [11:0] A_CAUSE   = 12'h342;
    localparam logic [11:0] A_TVAL    = 12'h343;
    localparam logic [11:0] A_CYCLE   = 12'hB00;
    localparam logic [11:0] A_INSTRET = 12'hB02;
    localparam logic [11:0] A_HARTID  = 12'hF14;

    localparam logic [XLEN-1:0] ISA_VALUE   = 32'h4000_0100;
    localparam logic [XLEN-1:0] CAUSE_ILL   = 32'd2;
    localparam logic [XLEN-1:0] CAUSE_BRK   = 32'd3;
    localparam logic [XLEN-1:0] CAUSE_ECALL = 32'd11;

    typedef struct packed {
        logic [XLEN-1:0] tvec;
        logic [XLEN-1:0] epc;
        logic [XLEN-1:0] cause;
        logic [XLEN-1:0] tval;
        logic            ie;
        logic            pie;
    } csr_state_t;

    function automatic logic [XLEN-1:0] apply_op(input logic [2:0] op,
                                                 input logic [XLEN-1:0] old,
                                                 input logic [XLEN-1:0] opnd);
        case (op)
            OP_WRITE: apply_op = opnd;
            OP_SET:   apply_op = old | opnd;
            OP_CLR:   apply_op = old & ~opnd;
            default:  apply_op = old;
        endcase
    endfunction

endpackage

// File: rtl/mcsr_counter.sv
module mcsr_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] cnt
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (wr_en)
            cnt_d = wr_data;
        else if (inc)
            cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    // R11
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && inc) |=> cnt == $past(cnt) + W'(1));
    // R12
    cnt_write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> cnt == $past(wr_data));
endmodule

// File: rtl/mcsr_trap_ctl.sv
module mcsr_trap_ctl
    import mcsr_pkg::*;
(
    input  logic [1:0]      kind,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] instr,
    output logic [XLEN-1:0] cause,
    output logic [XLEN-1:0] tval,
    output logic [XLEN-1:0] epc
);
    always_comb begin
        epc = {pc[XLEN-1:2], 2'b00};
        case (kind)
            TK_ECALL: begin
                cause = CAUSE_ECALL;
                tval  = '0;
            end
            TK_EBREAK: begin
                cause = CAUSE_BRK;
                tval  = pc;
            end
            default: begin
                cause = CAUSE_ILL;
                tval  = instr;
            end
        endcase
    end
endmodule

// File: rtl/mcsr_unit.sv
module mcsr_unit
    import mcsr_pkg::*;
#(
    parameter logic [31:0] HART_ID   = 32'd0,
    parameter logic [31:0] RESET_VEC = 32'h0000_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  csr_op,
    input  logic [11:0] csr_addr,
    input  logic [31:0] csr_wdata,
    output logic [31:0] csr_rdata,
    output logic        illegal_o,
    input  logic        retire_i,
    input  logic        trap_req,
    input  logic [1:0]  trap_kind,
    input  logic [31:0] trap_pc,
    input  logic [31:0] trap_instr,
    input  logic        mret_req,
    output logic [31:0] trap_vector_o,
    output logic [31:0] ret_addr_o
);
    localparam int NCNT = 2;

    csr_state_t state_d, state_q;

    logic [XLEN-1:0] t_cause, t_tval, t_epc;
    logic [XLEN-1:0] cnt_val [NCNT];
    logic [NCNT-1:0] cnt_inc, cnt_wr;
    logic            is_access, is_modify, known, read_only, wr_ok;
    logic [XLEN-1:0] status_rd, new_val;

    mcsr_trap_ctl u_trap (
        .kind  (trap_kind),
        .pc    (trap_pc),
        .instr (trap_instr),
        .cause (t_cause),
        .tval  (t_tval),
        .epc   (t_epc)
    );

    always_comb begin
        is_access = (csr_op >= OP_READ) && (csr_op <= OP_CLR);
        is_modify = (csr_op >= OP_WRITE) && (csr_op <= OP_CLR);
        read_only = (csr_addr[11:10] == 2'b11);
        known     = csr_addr inside {A_STATUS, A_ISA, A_TVEC, A_EPC, A_CAUSE,
                                     A_TVAL, A_CYCLE, A_INSTRET, A_HARTID};
        illegal_o = is_access && (!known || (read_only && is_modify));
        wr_ok     = is_modify && !illegal_o && !trap_req && !mret_req;

        status_rd = {19'b0, 2'b11, 3'b0, state_q.pie, 3'b0, state_q.ie, 3'b0};
        case (csr_addr)
            A_STATUS:  csr_rdata = status_rd;
            A_ISA:     csr_rdata = ISA_VALUE;
            A_TVEC:    csr_rdata = state_q.tvec;
            A_EPC:     csr_rdata = state_q.epc;
            A_CAUSE:   csr_rdata = state_q.cause;
            A_TVAL:    csr_rdata = state_q.tval;
            A_CYCLE:   csr_rdata = cnt_val[0];
            A_INSTRET: csr_rdata = cnt_val[1];
            A_HARTID:  csr_rdata = HART_ID;
            default:   csr_rdata = '0;
        endcase
        new_val = apply_op(csr_op, csr_rdata, csr_wdata);
    end

    always_comb begin
        state_d = state_q;
        if (trap_req) begin
            state_d.epc   = t_epc;
            state_d.cause = t_cause;
            state_d.tval  = t_tval;
            state_d.pie   = state_q.ie;
            state_d.ie    = 1'b0;
        end else if (mret_req) begin
            state_d.ie  = state_q.pie;
            state_d.pie = 1'b1;
        end else if (wr_ok) begin
            case (csr_addr)
                A_STATUS: begin
                    state_d.ie  = new_val[3];
                    state_d.pie = new_val[7];
                end
                A_TVEC: begin
                    state_d.tvec[XLEN-1:2] = new_val[XLEN-1:2];
                    if (!new_val[1])
                        state_d.tvec[1:0] = new_val[1:0];
                end
                A_EPC:   state_d.epc   = {new_val[XLEN-1:2], 2'b00};
                A_CAUSE: state_d.cause = new_val;
                A_TVAL:  state_d.tval  = new_val;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= '0;
            state_q.tvec  <= {RESET_VEC[31:2], 2'b00};
        end else begin
            state_q <= state_d;
        end
    end

    assign cnt_inc[0] = 1'b1;
    assign cnt_inc[1] = retire_i;
    assign cnt_wr[0]  = wr_ok && (csr_addr == A_CYCLE);
    assign cnt_wr[1]  = wr_ok && (csr_addr == A_INSTRET);

    for (genvar gi = 0; gi < NCNT; gi++) begin : g_cnt
        mcsr_counter #(.W(XLEN)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .inc     (cnt_inc[gi]),
            .wr_en   (cnt_wr[gi]),
            .wr_data (new_val),
            .cnt     (cnt_val[gi])
        );
    end

    assign trap_vector_o = {state_q.tvec[XLEN-1:2], 2'b00};
    assign ret_addr_o    = state_q.epc;

    // R6
    epc_trap_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> ret_addr_o == {$past(trap_pc[31:2]), 2'b00});
    // R5
    tvec_mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.tvec[1] == 1'b0);
    // R8
    ecall_tval_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && trap_kind == TK_ECALL) |=> state_q.tval == '0);
    // R7
    ebreak_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && trap_kind == TK_EBREAK) |=> state_q.cause == CAUSE_BRK);
    // R9
    trap_clears_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> (!state_q.ie && state_q.pie == $past(state_q.ie)));
    // R2
    ro_write_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_addr == A_HARTID && csr_op == OP_WRITE) |-> illegal_o);
    // R4
    isa_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_addr == A_ISA) |-> csr_rdata == ISA_VALUE);
endmodule

// File: tb/mcsr_unit_tb_top.sv
module mcsr_unit_tb_top;
    localparam logic [31:0] HID  = 32'd5;
    localparam logic [31:0] RVEC = 32'h0000_0102;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  csr_op;
    logic [11:0] csr_addr;
    logic [31:0] csr_wdata, csr_rdata, trap_pc, trap_instr, trap_vector_o, ret_addr_o;
    logic        illegal_o, retire_i, trap_req, mret_req;
    logic [1:0]  trap_kind;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    mcsr_unit #(.HART_ID(HID), .RESET_VEC(RVEC)) dut_i (
        .clk(clk), .rst_n(rst_n), .csr_op(csr_op), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .illegal_o(illegal_o),
        .retire_i(retire_i), .trap_req(trap_req), .trap_kind(trap_kind),
        .trap_pc(trap_pc), .trap_instr(trap_instr), .mret_req(mret_req),
        .trap_vector_o(trap_vector_o), .ret_addr_o(ret_addr_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic idle();
        csr_op = 3'd0; csr_addr = 12'h0; csr_wdata = 0; retire_i = 0;
        trap_req = 0; trap_kind = 0; trap_pc = 0; trap_instr = 0; mret_req = 0;
    endtask

    // one cycle of stimulus: set at a falling edge, held across one rising edge
    task automatic cyc(input logic [2:0] op, input logic [11:0] a, input logic [31:0] d,
                       input logic ret, input logic trq, input logic [1:0] k,
                       input logic [31:0] pc, input logic [31:0] ins, input logic mr);
        @(negedge clk);
        csr_op = op; csr_addr = a; csr_wdata = d; retire_i = ret;
        trap_req = trq; trap_kind = k; trap_pc = pc; trap_instr = ins; mret_req = mr;
        @(negedge clk);
        idle();
    endtask

    task automatic wr(input logic [2:0] op, input logic [11:0] a, input logic [31:0] d);
        cyc(op, a, d, 1'b0, 1'b0, 2'd0, 32'd0, 32'd0, 1'b0);
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        csr_op = 3'd1; csr_addr = a;
        #1 v = csr_rdata;
        csr_op = 3'd0;
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [11:0] addrs [13];
        logic [1:0]  prev_mode;
        addrs = '{12'h300, 12'h301, 12'h305, 12'h341, 12'h342, 12'h343, 12'hB00,
                  12'hB02, 12'hF14, 12'h000, 12'h304, 12'hB01, 12'hF11};
        idle();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset values
        rd(12'h301, v); chk("R1 isa", v, 32'h4000_0100);
        rd(12'hF14, v); chk("R1 hartid", v, HID);
        rd(12'h300, v); chk("R1 status", v, 32'h1800);
        rd(12'h305, v); chk("R1 tvec", v, 32'h100);
        rd(12'h341, v); chk("R1 epc", v, 0);
        rd(12'h342, v); chk("R1 cause", v, 0);
        rd(12'h343, v); chk("R1 tval", v, 0);
        rd(12'hB02, v); chk("R1 instret", v, 0);

        // R2 legality sweep: every op code against implemented and unused addresses
        for (int ai = 0; ai < 13; ai++) begin
            for (int op = 0; op < 8; op++) begin
                logic acc, known, ro, exp;
                @(negedge clk);
                csr_op = 3'(op); csr_addr = addrs[ai];
                acc   = (op >= 1 && op <= 4);
                known = (ai < 9);
                ro    = (addrs[ai][11:10] == 2'b11);
                exp   = acc && (!known || (ro && op >= 2));
                #1 chk("R2 illegal flag", {31'b0, illegal_o}, {31'b0, exp});
                #1 csr_op = 3'd0;
            end
        end
        wr(3'd2, 12'hF14, 32'hFFFF_FFFF);
        rd(12'hF14, v); chk("R2 ro write ignored", v, HID);
        wr(3'd2, 12'h304, 32'hFFFF_FFFF);
        rd(12'h300, v); chk("R2 unknown write ignored", v, 32'h1800);

        // R3 status bit semantics
        wr(3'd2, 12'h300, 32'hFFFF_FFFF); rd(12'h300, v); chk("R3 write", v, 32'h1888);
        wr(3'd4, 12'h300, 32'h8);         rd(12'h300, v); chk("R3 clear", v, 32'h1880);
        wr(3'd3, 12'h300, 32'h0);         rd(12'h300, v); chk("R3 set zero", v, 32'h1880);
        wr(3'd4, 12'h300, 32'h80);        rd(12'h300, v); chk("R3 clear pie", v, 32'h1800);
        wr(3'd3, 12'h300, 32'h8);         rd(12'h300, v); chk("R3 set ie", v, 32'h1808);

        // R4 ISA register immune to writes
        for (int op = 2; op <= 4; op++) begin
            @(negedge clk);
            csr_op = 3'(op); csr_addr = 12'h301; csr_wdata = 32'h0000_FFFF;
            #1 chk("R4 no flag", {31'b0, illegal_o}, 0);
            @(negedge clk); idle();
            rd(12'h301, v); chk("R4 isa kept", v, 32'h4000_0100);
        end

        // R5 / R10 trap-vector mode legalization sweep
        prev_mode = 2'd0;
        for (int bi = 0; bi < 2; bi++) begin
            for (int m = 0; m < 4; m++) begin
                logic [31:0] base;
                base = (bi == 0) ? 32'h0000_1000 : 32'h0002_A40C;
                if (m < 2) prev_mode = 2'(m);
                wr(3'd2, 12'h305, base | 32'(m));
                rd(12'h305, v); chk("R5 tvec", v, (base & ~32'h3) | {30'b0, prev_mode});
                chk("R10 vector", trap_vector_o, base & ~32'h3);
            end
        end

        // R6 exception-PC alignment under software writes
        for (int lo = 0; lo < 4; lo++) begin
            wr(3'd2, 12'h341, 32'h0000_8000 | 32'(lo));
            rd(12'h341, v); chk("R6 epc", v, 32'h0000_8000);
            chk("R10 ret addr", ret_addr_o, 32'h0000_8000);
        end

        // R7 / R8 trap kind sweep
        for (int k = 0; k < 4; k++) begin
            logic [31:0] pc, ins, ecause, etval;
            pc  = 32'h2000 + 32'(k) * 8 + 32'(k & 1) * 2;
            ins = 32'hDEAD_0000 | 32'(k);
            ecause = (k == 1) ? 32'd11 : (k == 2) ? 32'd3 : 32'd2;
            etval  = (k == 1) ? 32'd0 : (k == 2) ? pc : ins;
            cyc(3'd0, 12'h0, 0, 1'b0, 1'b1, 2'(k), pc, ins, 1'b0);
            rd(12'h342, v); chk("R7 cause", v, ecause);
            rd(12'h341, v); chk("R7 epc", v, pc & ~32'h3);
            rd(12'h343, v); chk("R8 tval", v, etval);
            chk("R10 ret addr", ret_addr_o, pc & ~32'h3);
        end

        // R9 enable stacking
        wr(3'd2, 12'h300, 32'h8);
        cyc(3'd0, 12'h0, 0, 1'b0, 1'b1, 2'd1, 32'h40, 0, 1'b0);
        rd(12'h300, v); chk("R9 trap ie=1", v, 32'h1880);
        cyc(3'd0, 12'h0, 0, 1'b0, 1'b0, 2'd0, 0, 0, 1'b1);
        rd(12'h300, v); chk("R9 mret", v, 32'h1888);
        wr(3'd2, 12'h300, 32'h0);
        cyc(3'd0, 12'h0, 0, 1'b0, 1'b1, 2'd2, 32'h44, 0, 1'b0);
        rd(12'h300, v); chk("R9 trap ie=0", v, 32'h1800);
        cyc(3'd0, 12'h0, 0, 1'b0, 1'b0, 2'd0, 0, 0, 1'b1);
        rd(12'h300, v); chk("R9 mret pie=0", v, 32'h1880);

        // R11 cycle counter: written value then one per edge
        foreach (addrs[i]) begin
            if (i < 3) begin
                int k;
                k = (i == 0) ? 0 : (i == 1) ? 3 : 17;
                wr(3'd2, 12'hB00, 32'd100);
                repeat (k) @(negedge clk);
                rd(12'hB00, v); chk("R11 cycle", v, 32'd100 + 32'(k));
            end
        end

        // R12 retired counter with a colliding retire
        cyc(3'd2, 12'hB02, 32'd50, 1'b1, 1'b0, 2'd0, 0, 0, 1'b0);
        rd(12'hB02, v); chk("R12 write beats retire", v, 32'd50);
        for (int r = 1; r <= 5; r++) begin
            cyc(3'd0, 12'h0, 0, 1'b1, 1'b0, 2'd0, 0, 0, 1'b0);
            rd(12'hB02, v); chk("R12 retire count", v, 32'd50 + 32'(r));
        end
        repeat (4) @(negedge clk);
        rd(12'hB02, v); chk("R12 no retire no count", v, 32'd55);
        cyc(3'd3, 12'hB02, 32'h100, 1'b1, 1'b0, 2'd0, 0, 0, 1'b0);
        rd(12'hB02, v); chk("R12 set beats retire", v, 32'd55 | 32'h100);

        // R13 trap and return beat a simultaneous access
        cyc(3'd2, 12'h343, 32'h55, 1'b0, 1'b1, 2'd1, 32'h80, 32'h1234, 1'b0);
        rd(12'h343, v); chk("R13 trap over write", v, 0);
        wr(3'd2, 12'h341, 32'h300);
        cyc(3'd2, 12'h341, 32'h700, 1'b0, 1'b0, 2'd0, 0, 0, 1'b1);
        rd(12'h341, v); chk("R13 mret over write", v, 32'h300);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule